// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is the target (slave) end of a two-wire serial bus. It watches the clock and data lines and finds the START, repeated START and STOP conditions. After each START it shifts in an address frame and compares it with a 7-bit address supplied on a port. On a match it acknowledges and then receives bytes from the controller or sends bytes to it. The read/write bit of the address frame selects the direction. A byte-wide user side connects the block to the rest of the chip. Received bytes leave on a valid/ready pair. Bytes to send enter on a second valid/ready pair.

The block never drives a line high. Each output is a pull-low enable for an open-drain pad, and the external pull-up takes a released line high. Whenever the user side has not yet taken a received byte, or has not yet offered the next byte to send, the block holds the clock line low. This stalls the controller until the user side catches up. Both bus inputs pass through a two-flop synchroniser and a stability filter before any edge is detected.

Top module: `i2c_stretch_target`

## Requirements
- R1: After reset both pull-low outputs are 0, `rx_valid` is 0 and `tx_ready` is 0, and `rx_valid` and `tx_ready` are never high together.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either is recognised at any point of a transfer. A START inside a transaction restarts address reception at once. After a STOP both lines are released.
- R3: The first byte after a START is taken MSB first. Bits 7..1 form the address and bit 0 is the direction (0 = controller writes, 1 = controller reads). The target pulls SDA low during the ninth clock only when bits 7..1 equal `own_addr`.
- R4: On an address mismatch the target leaves SDA and SCL released until the next START or STOP and delivers no bytes on the receive side.
- R5: In write direction each 8-bit byte, MSB first on the bus, appears on `rx_data` with `rx_valid`. `rx_data` stays stable until `rx_ready` is seen. The target then acknowledges the byte by pulling SDA low during the ninth clock.
- R6: While a received byte waits for `rx_ready`, the target holds SCL low.
- R7: In read direction each byte accepted on the transmit handshake is driven MSB first. SDA is changed only while SCL is low, and `tx_ready` drops in the cycle after a handshake.
- R8: While `tx_ready` is high and no byte is offered, the target holds SCL low.
- R9: If the controller answers a sent byte with NACK (SDA high in the ninth clock), the target releases SDA and raises `tx_ready` no more until the next START.
- R10: A pulse on a bus line that lasts fewer than `FILT_LEN` clock cycles is ignored and does not disturb bit counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 7 | Address this target answers to |
| scl_in | input | 1 | Level sensed on the clock line |
| sda_in | input | 1 | Level sensed on the data line |
| scl_pull | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| rx_data | output | 8 | Byte received from the controller |
| rx_valid | output | 1 | `rx_data` holds a byte not yet taken |
| rx_ready | input | 1 | User side takes the pending received byte |
| tx_data | input | 8 | Byte to send to the controller |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Target wants the next byte to send |

## Verification
The bench targets these corner cases:
- A user side that is slow in each direction. The clock line must stay low while the controller tries to raise it, and the byte must arrive intact afterwards. A design that skipped stretching would let the controller clock out stale data or lose a byte.
- A repeated START after a mismatched address, and another after a write that switches to a read. A design that waited for idle would miss the second address.
- A mismatched frame followed by a data byte. The target must stay silent throughout, so a design that acknowledged loosely would pull SDA.
- A controller NACK that must end the read with no further byte request.
- A two-cycle dip on the clock line in the middle of the address. Without the filter this dip adds a phantom bit, and the acknowledge is lost.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared widths and the protocol state type for the I2C target.
// Assumes 7-bit addressing and 8-bit data frames only.
package i2c_tgt_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,      // bus free, nothing to do
        ST_ADDR,      // shifting in the address frame
        ST_ADDR_ACK,  // pulling SDA low for the address acknowledge
        ST_RX_BYTE,   // shifting in a data byte from the controller
        ST_RX_HOLD,   // byte waiting for the user side, SCL stretched
        ST_RX_ACK,    // byte taken, acknowledge bit on the bus
        ST_TX_LOAD,   // waiting for a byte to send, SCL stretched
        ST_TX_BYTE,   // driving a data byte to the controller
        ST_TX_ACK,    // reading the controller's acknowledge
        ST_IGNORE     // not addressed or read ended, lines released
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_line_filter.sv
// Module: i2c_tgt_line_filter
// Brings each asynchronous bus line into the clock domain with a two-flop
// synchroniser. It then passes a new level on only after that level has
// stayed put for FILT_LEN consecutive cycles.
// Assumes the lines idle high (pulled up), so every stage resets to 1.
module i2c_tgt_line_filter #(
    parameter int NLINES   = 2,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] raw,
    output logic [NLINES-1:0] clean
);

    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN - 1);

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic          sync_a;
        logic          sync_b;
        logic          level;
        logic [CW-1:0] run;

        // Two-flop synchroniser against metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_a <= 1'b1;
                sync_b <= 1'b1;
            end else begin
                sync_a <= raw[g];
                sync_b <= sync_a;
            end
        end

        // Accept a new level only after it has held for FILT_LEN cycles.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level <= 1'b1;
                run   <= '0;
            end else if (sync_b == level) begin
                run <= '0;
            end else if (run == LIMIT) begin
                level <= sync_b;
                run   <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end

        assign clean[g] = level;
    end

endmodule

// File: rtl/i2c_tgt_bus_cond.sv
// Module: i2c_tgt_bus_cond
// Turns the filtered clock and data levels into one-cycle events: START,
// STOP, clock rising and clock falling.
// Assumes both inputs come from the same filter, so they keep the order in
// which they changed on the bus.
module i2c_tgt_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_d;
    logic sda_d;

    // Keep the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Decode the bus conditions from the level pairs.
    always_comb begin
        start_det = scl_f & scl_d & sda_d & ~sda_f;
        stop_det  = scl_f & scl_d & ~sda_d & sda_f;
        scl_rise  = scl_f & ~scl_d;
        scl_fall  = ~scl_f & scl_d;
    end

endmodule

// File: rtl/i2c_tgt_fsm.sv
// Module: i2c_tgt_fsm
// The protocol engine. It counts bits, matches the address, moves bytes in
// both directions and decides when to pull SDA or SCL low.
// Assumes one-cycle START/STOP/edge events from i2c_tgt_bus_cond. START
// has priority over STOP, and both have priority over the current state.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int SETUP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_f,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int SU_W  = $clog2(SETUP_CYC + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
    localparam logic [SU_W-1:0]  SU_LOAD = SU_W'(SETUP_CYC);

    tgt_state_e        state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] rx_q;
    logic              rw_q;
    logic              nack_q;
    logic [SU_W-1:0]   su_cnt;
    logic              addr_hit;
    logic              tx_take;

    assign addr_hit = (shreg[BYTE_W-1 -: ADDR_W] == own_addr);
    assign tx_take  = (state == ST_TX_LOAD) && tx_valid;

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            rx_q   <= '0;
            rw_q   <= 1'b0;
            nack_q <= 1'b0;
        end else if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
        end else if (stop_det) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_f};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == FULL) begin
                        if (addr_hit) begin
                            state <= ST_ADDR_ACK;
                            rw_q  <= shreg[0];
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        state  <= rw_q ? ST_TX_LOAD : ST_RX_BYTE;
                    end
                end
                ST_RX_BYTE: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_f};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == FULL) begin
                        rx_q  <= shreg;
                        state <= ST_RX_HOLD;
                    end
                end
                ST_RX_HOLD: begin
                    if (rx_ready) begin
                        state <= ST_RX_ACK;
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        state  <= ST_RX_BYTE;
                    end
                end
                ST_TX_LOAD: begin
                    if (tx_take) begin
                        shreg  <= tx_data;
                        bitcnt <= '0;
                        state  <= ST_TX_BYTE;
                    end
                end
                ST_TX_BYTE: begin
                    if (scl_fall) begin
                        if (bitcnt == LAST) begin
                            state <= ST_TX_ACK;
                        end else begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b1};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        nack_q <= sda_f;
                    end else if (scl_fall) begin
                        state <= nack_q ? ST_IGNORE : ST_TX_LOAD;
                    end
                end
                default: begin
                    state <= state;
                end
            endcase
        end
    end

    // Keep SCL low for a few cycles after a load so that SDA settles first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            su_cnt <= '0;
        end else if (tx_take) begin
            su_cnt <= SU_LOAD;
        end else if (su_cnt != '0) begin
            su_cnt <= su_cnt - 1'b1;
        end
    end

    // Derive the open-drain enables and the handshake outputs from the state.
    always_comb begin
        sda_pull = (state == ST_ADDR_ACK) || (state == ST_RX_HOLD) ||
                   (state == ST_RX_ACK) ||
                   ((state == ST_TX_BYTE) && !shreg[BYTE_W-1]);
        scl_pull = (state == ST_RX_HOLD) || (state == ST_TX_LOAD) ||
                   (su_cnt != '0);
        rx_valid = (state == ST_RX_HOLD);
        tx_ready = (state == ST_TX_LOAD);
        rx_data  = rx_q;
    end

endmodule

// File: rtl/i2c_stretch_target.sv
// Module: i2c_stretch_target
// Top of the I2C target: line filter, bus-condition decoder and protocol
// engine. The pull outputs drive open-drain pads, where 1 means pull low.
// Assumes scl_in/sda_in read the wired bus levels, including this block's
// own pulls.
module i2c_stretch_target
    import i2c_tgt_pkg::*;
#(
    parameter int FILT_LEN  = 3,
    parameter int SETUP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);

    logic [1:0] lines_clean;
    logic       scl_filt;
    logic       sda_filt;
    logic       start_det;
    logic       stop_det;
    logic       scl_rise;
    logic       scl_fall;

    i2c_tgt_line_filter #(
        .NLINES   (2),
        .FILT_LEN (FILT_LEN)
    ) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({scl_in, sda_in}),
        .clean (lines_clean)
    );

    assign scl_filt = lines_clean[1];
    assign sda_filt = lines_clean[0];

    i2c_tgt_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_filt),
        .sda_f     (sda_filt),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    i2c_tgt_fsm #(
        .SETUP_CYC (SETUP_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_f     (sda_filt),
        .own_addr  (own_addr),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready)
    );

endmodule

// File: rtl/i2c_stretch_target_chk.sv
// Module: i2c_stretch_target_chk
// Property checker attached to i2c_stretch_target with bind. It watches the
// ports plus the filtered clock level and the STOP event.
module i2c_stretch_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       scl_f,
    input logic       stop_det
);

    // R1: the two user-side requests never overlap.
    p_one_side_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, tx_ready}));

    // R2: after a STOP both lines are released.
    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!scl_pull && !sda_pull));

    // R5: a pending received byte holds its value until taken.
    p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R6: a pending received byte stretches the clock.
    p_rx_stretch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> scl_pull);

    // R7: SDA drive changes only while the clock is low.
    p_sda_low_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_f);

    // R7: the transmit request drops after a handshake.
    p_tx_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_valid) |=> !tx_ready);

    // R8: waiting for a byte to send stretches the clock.
    p_tx_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |-> scl_pull);

endmodule

bind i2c_stretch_target i2c_stretch_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .scl_f    (scl_filt),
    .stop_det (stop_det)
);

// File: tb/i2c_stretch_target_tb_top.sv
`timescale 1ns/1ps
// Directed bench: a controller model on a wired-AND bus and user-side
// drivers. Each scenario is one task that checks its own results.
module i2c_stretch_target_tb_top;

    localparam int Q = 20;
    localparam logic [6:0] ADDR = 7'h3A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       rx_ready = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       scl_pull, sda_pull, rx_valid, tx_ready;
    logic [7:0] rx_data;
    logic       scl_w, sda_w;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rx_log [0:31];
    int rx_cnt = 0;
    int tx_hs = 0;
    int sda_drive = 0;
    int bad_sda_edge = 0;
    logic p_pull = 1'b0;
    logic p_scl = 1'b1;
    logic glitch_en = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign scl_w = m_scl & ~scl_pull;
    assign sda_w = m_sda & ~sda_pull;

    i2c_stretch_target dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .own_addr (ADDR),
        .scl_in   (scl_w),
        .sda_in   (sda_w),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_ready (rx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready)
    );

    // Record handshakes and watch SDA drive against the clock line.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && rx_ready) begin
                rx_log[rx_cnt % 32] = rx_data;
                rx_cnt++;
            end
            if (tx_ready && tx_valid) tx_hs++;
            if (sda_pull) sda_drive++;
            if (sda_pull != p_pull && scl_w && p_scl) bad_sda_edge++;
        end
        p_pull = sda_pull;
        p_scl  = scl_w;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; m_scl = 1'b1; wait_cyc(Q);
        m_sda = 1'b0; wait_cyc(Q);
        m_scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic m_rstart();
        m_sda = 1'b1; wait_cyc(Q);
        m_scl = 1'b1; wait_cyc(Q);
        m_sda = 1'b0; wait_cyc(Q);
        m_scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wait_cyc(Q);
        m_scl = 1'b1; wait_cyc(Q);
        m_sda = 1'b1; wait_cyc(Q);
    endtask

    // One clock: set SDA while low, release SCL, wait out stretching, sample.
    task automatic m_bit(input logic b, output logic r);
        m_sda = b; wait_cyc(Q);
        m_scl = 1'b1;
        do @(negedge clk); while (!scl_w);
        if (glitch_en) begin
            wait_cyc(Q / 2);
            m_scl = 1'b0; wait_cyc(2);
            m_scl = 1'b1; wait_cyc(Q / 2);
            glitch_en = 1'b0;
        end else begin
            wait_cyc(Q);
        end
        r = sda_w;
        wait_cyc(Q);
        m_scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(d[i], r);
        m_bit(1'b1, ack);
    endtask

    task automatic m_rbyte(input logic ackbit, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(1'b1, d[i]);
        m_bit(ackbit, r);
    endtask

    task automatic feed(input logic [7:0] d, input int delay);
        while (!tx_ready) @(negedge clk);
        wait_cyc(delay);
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic check_released(input string req);
        wait_cyc(10);
        chk(req, "scl released", int'(scl_pull), 0);
        chk(req, "sda released", int'(sda_pull), 0);
    endtask

    task automatic t_reset();
        chk("R1", "scl_pull", int'(scl_pull), 0);
        chk("R1", "sda_pull", int'(sda_pull), 0);
        chk("R1", "rx_valid", int'(rx_valid), 0);
        chk("R1", "tx_ready", int'(tx_ready), 0);
    endtask

    task automatic t_write();
        logic ack;
        int base = rx_cnt;
        m_start();
        m_wbyte({ADDR, 1'b0}, ack); chk("R3", "addr ack write", int'(ack), 0);
        m_wbyte(8'hA5, ack);        chk("R5", "ack byte0", int'(ack), 0);
        m_wbyte(8'h3C, ack);        chk("R5", "ack byte1", int'(ack), 0);
        m_stop();
        chk("R5", "rx count", rx_cnt - base, 2);
        chk("R5", "byte0", int'(rx_log[base % 32]), 'hA5);
        chk("R5", "byte1", int'(rx_log[(base + 1) % 32]), 'h3C);
        check_released("R2");
    endtask

    task automatic t_mismatch();
        logic ack;
        int base = rx_cnt;
        sda_drive = 0;
        m_start();
        m_wbyte({7'h3B, 1'b0}, ack); chk("R3", "no ack on mismatch", int'(ack), 1);
        m_wbyte(8'h00, ack);         chk("R4", "no ack data", int'(ack), 1);
        chk("R4", "sda never pulled", sda_drive, 0);
        chk("R4", "no rx byte", rx_cnt - base, 0);
        m_stop();
        check_released("R4");
    endtask

    task automatic t_rstart();
        logic ack;
        logic [7:0] d;
        int base = rx_cnt;
        m_start();
        m_wbyte({7'h11, 1'b0}, ack); chk("R2", "mismatch before rstart", int'(ack), 1);
        m_rstart();
        m_wbyte({ADDR, 1'b0}, ack); chk("R2", "ack after rstart", int'(ack), 0);
        m_wbyte(8'h81, ack);        chk("R2", "byte ack after rstart", int'(ack), 0);
        chk("R2", "rx after rstart", int'(rx_log[base % 32]), 'h81);
        m_rstart();
        fork
            feed(8'h17, 0);
            begin
                m_wbyte({ADDR, 1'b1}, ack); chk("R2", "read ack after rstart", int'(ack), 0);
                m_rbyte(1'b1, d);           chk("R7", "read byte after rstart", int'(d), 'h17);
            end
        join
        m_stop();
        check_released("R2");
    endtask

    task automatic t_read();
        logic ack;
        logic [7:0] d0, d1;
        int hs0 = tx_hs;
        bad_sda_edge = 0;
        m_start();
        fork
            begin feed(8'hC3, 0); feed(8'h5A, 0); end
            begin
                m_wbyte({ADDR, 1'b1}, ack); chk("R3", "addr ack read", int'(ack), 0);
                m_rbyte(1'b0, d0);
                m_rbyte(1'b1, d1);
            end
        join
        chk("R7", "read byte0", int'(d0), 'hC3);
        chk("R7", "read byte1", int'(d1), 'h5A);
        chk("R7", "sda changed only with scl low", bad_sda_edge, 0);
        wait_cyc(200);
        chk("R9", "no request after nack", int'(tx_ready), 0);
        chk("R9", "sda released after nack", int'(sda_pull), 0);
        chk("R9", "handshake count", tx_hs - hs0, 2);
        m_stop();
    endtask

    task automatic t_rx_stretch();
        logic ack;
        int base = rx_cnt;
        rx_ready = 1'b0;
        m_start();
        fork
            begin
                m_wbyte({ADDR, 1'b0}, ack);
                m_wbyte(8'h66, ack);
                chk("R5", "ack after stretch", int'(ack), 0);
            end
            begin
                while (!rx_valid) @(negedge clk);
                chk("R6", "rx_data during hold", int'(rx_data), 'h66);
                wait_cyc(100);
                chk("R6", "controller high", int'(m_scl), 1);
                chk("R6", "scl held low", int'(scl_w), 0);
                rx_ready = 1'b1;
            end
        join
        m_stop();
        chk("R6", "byte after stretch", int'(rx_log[base % 32]), 'h66);
    endtask

    task automatic t_tx_stretch();
        logic ack;
        logic [7:0] d;
        m_start();
        fork
            feed(8'h96, 150);
            begin
                while (!tx_ready) @(negedge clk);
                wait_cyc(100);
                chk("R8", "controller high", int'(m_scl), 1);
                chk("R8", "scl held low", int'(scl_w), 0);
            end
            begin
                m_wbyte({ADDR, 1'b1}, ack);
                m_rbyte(1'b1, d);
                chk("R8", "byte after stretch", int'(d), 'h96);
            end
        join
        m_stop();
    endtask

    task automatic t_glitch();
        logic ack, r;
        logic [7:0] a;
        int base = rx_cnt;
        a = {ADDR, 1'b0};
        m_start();
        for (int i = 7; i >= 0; i--) begin
            if (i == 3) glitch_en = 1'b1;
            m_bit(a[i], r);
        end
        m_bit(1'b1, ack);
        chk("R10", "ack despite scl glitch", int'(ack), 0);
        m_wbyte(8'h5E, ack);
        m_stop();
        chk("R10", "byte despite scl glitch", int'(rx_log[base % 32]), 'h5E);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_write();
        t_mismatch();
        t_rstart();
        t_read();
        t_rx_stretch();
        t_tx_stretch();
        t_glitch();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule